// File: doc/BRIEF.md
# Card Host Data FIFO with Threshold Requests

This block is the word buffer between a processor bus and the data path of a memory-card host. It stores 32 words of 16 bits in first-in first-out order. A writer pushes words and a reader pops them. The oldest word is always visible on the read port. Only the fill count and the level indications are in scope. The card-side serializer and clock generation are not part of the block.

A single 16-bit buffer-setup register holds two thresholds and two DMA enables. For receive transfers the block watches for the buffer running high. For transmit transfers it watches for the buffer running low. The `xfer_dir` input selects which of the two is watched. When the watched condition holds, the block raises one of two indications for that direction: a DMA request if that direction's DMA enable is set, or a polled status flag if it is clear. When no transfer is running and the buffer is empty, all four indications are forced low.

Top module: `mcf_top`

## Requirements
- R1: Words leave in the order they were accepted. The read and write positions wrap modulo 32, and `rd_data` always shows the oldest stored word.
- R2: A push while `fill` is 32 is dropped, and `fill` stays at 32.
- R3: A pop while `fill` is 0 is ignored. `fill` stays 0, and `rd_data` keeps showing the word at the head position.
- R4: A push and a pop in the same cycle are both taken when `fill` is between 1 and 31, leaving `fill` unchanged. When full, only the pop is taken. When empty, only the push is taken.
- R5: The setup register has this layout: bit 15 is the receive DMA enable, bits 12:8 are the high mark, bit 7 is the transmit DMA enable, bits 4:0 are the low mark, and the other bits read 0. After reset it reads 0x1F00.
- R6: With `xfer_dir`=1 and `fill` greater than the high mark, `rx_dma_req` is 1 if receive DMA is enabled. Otherwise `rx_lvl_flag` is 1.
- R7: With `xfer_dir`=0 and `fill` less than the low mark, `tx_dma_req` is 1 if transmit DMA is enabled. Otherwise `tx_lvl_flag` is 1.
- R8: A direction whose condition does not hold, including the direction not selected by `xfer_dir`, has both its request and its flag at 0. At most one of the four indications is 1 at any time.
- R9: When `xfer_active` is 0 and `fill` is 0, all four indications are 0 in the following cycle.
- R10: Writing a setup value whose DMA enable bit is 1 clears the matching status flag at the same clock edge that loads the register.
- R11: The indications are registered and follow `fill` with one cycle of delay. After a push or pop edge, `fill` changes at once and the indications change one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Store `wr_data` this cycle |
| wr_data | input | 16 | Word to store |
| pop | input | 1 | Drop the head word this cycle |
| rd_data | output | 16 | Head word |
| fill | output | 6 | Number of stored words, 0 to 32 |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = receive (watch high mark), 0 = transmit (watch low mark) |
| cfg_we | input | 1 | Load the setup register |
| cfg_wdata | input | 16 | Setup value to load |
| cfg_rdata | output | 16 | Current setup register |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_lvl_flag | output | 1 | Receive polled level flag |
| tx_lvl_flag | output | 1 | Transmit polled level flag |

## Verification
Two pairs of functions can land on the same edge. The first is a push together with a pop. The bench drives both at once with the buffer empty, partly filled and full, then checks the resulting `fill` against the acceptance rule of R4 and checks the head word against a queue model. The second is a setup write that sets a DMA enable while the polled flag for that direction is high. The bench checks, at the edge that loads the register, that the flag falls and the request rises. Threshold sweeps step `fill` through 0 to 32 under several marks and enable settings in both directions, and compare the four indications with values worked out from the compare rules.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam int MCF_LVL_W = 5;
    localparam int MCF_RXEN_BIT = 15;
    localparam int MCF_HI_LSB = 8;
    localparam int MCF_TXEN_BIT = 7;
    localparam int MCF_LO_LSB = 0;

    typedef struct packed {
        logic                 rx_en;
        logic [MCF_LVL_W-1:0] hi_mark;
        logic                 tx_en;
        logic [MCF_LVL_W-1:0] lo_mark;
    } mcf_cfg_t;

    typedef struct packed {
        logic rx_req;
        logic rx_flag;
        logic tx_req;
        logic tx_flag;
    } mcf_ind_t;
endpackage

// File: rtl/mcf_store.sv
module mcf_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic push_ok, pop_ok;
    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (push_ok) st_d.wp = st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= wr_data;
    end

    assign rd_data = mem[st_q.rp];
    assign count   = st_q.cnt;
endmodule

// File: rtl/mcf_level.sv
module mcf_level
    import mcf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             xfer_active,
    input  logic             xfer_dir,
    input  mcf_cfg_t         cfg_nx,
    output mcf_ind_t         ind
);
    mcf_ind_t ind_d, ind_q;
    logic idle_empty, hi_hit, lo_hit;

    always_comb begin
        idle_empty = !xfer_active && (count == '0);
        hi_hit     = xfer_dir && (count > CNT_W'(cfg_nx.hi_mark));
        lo_hit     = !xfer_dir && (count < CNT_W'(cfg_nx.lo_mark));
        ind_d      = '0;
        if (!idle_empty) begin
            ind_d.rx_req  = hi_hit && cfg_nx.rx_en;
            ind_d.rx_flag = hi_hit && !cfg_nx.rx_en;
            ind_d.tx_req  = lo_hit && cfg_nx.tx_en;
            ind_d.tx_flag = lo_hit && !cfg_nx.tx_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ind_q <= '0;
        else        ind_q <= ind_d;
    end

    assign ind = ind_q;
endmodule

// File: rtl/mcf_top.sv
module mcf_top
    import mcf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] fill,
    input  logic             xfer_active,
    input  logic             xfer_dir,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             rx_lvl_flag,
    output logic             tx_lvl_flag
);
    mcf_cfg_t cfg_d, cfg_q;
    mcf_ind_t ind;
    logic unused_cfg_bits;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.rx_en   = cfg_wdata[MCF_RXEN_BIT];
            cfg_d.hi_mark = cfg_wdata[MCF_HI_LSB +: MCF_LVL_W];
            cfg_d.tx_en   = cfg_wdata[MCF_TXEN_BIT];
            cfg_d.lo_mark = cfg_wdata[MCF_LO_LSB +: MCF_LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.rx_en   <= 1'b0;
            cfg_q.hi_mark <= MCF_LVL_W'(DEPTH - 1);
            cfg_q.tx_en   <= 1'b0;
            cfg_q.lo_mark <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[MCF_RXEN_BIT]             = cfg_q.rx_en;
        cfg_rdata[MCF_HI_LSB +: MCF_LVL_W]  = cfg_q.hi_mark;
        cfg_rdata[MCF_TXEN_BIT]             = cfg_q.tx_en;
        cfg_rdata[MCF_LO_LSB +: MCF_LVL_W]  = cfg_q.lo_mark;
    end

    assign unused_cfg_bits = ^cfg_wdata;

    mcf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_data (rd_data),
        .count   (fill)
    );

    mcf_level #(.CNT_W(CNT_W)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (fill),
        .xfer_active (xfer_active),
        .xfer_dir    (xfer_dir),
        .cfg_nx      (cfg_d),
        .ind         (ind)
    );

    assign rx_dma_req  = ind.rx_req;
    assign rx_lvl_flag = ind.rx_flag;
    assign tx_dma_req  = ind.tx_req;
    assign tx_lvl_flag = ind.tx_flag;
endmodule

// File: rtl/mcf_chk.sv
module mcf_chk #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic [WIDTH-1:0] rd_data,
    input logic [CNT_W-1:0] fill,
    input logic             xfer_active,
    input logic             xfer_dir,
    input logic             cfg_we,
    input logic [15:0]      cfg_wdata,
    input logic [15:0]      cfg_rdata,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic             rx_lvl_flag,
    input logic             tx_lvl_flag
);
    logic [CNT_W-1:0] hi_ext, lo_ext;
    assign hi_ext = CNT_W'(cfg_rdata[12:8]);
    assign lo_ext = CNT_W'(cfg_rdata[4:0]);

    // R1
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH) && push && !pop) |=> (fill == CNT_W'(DEPTH)));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && pop && !push) |=> (fill == '0 && $stable(rd_data)));

    // R6
    rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && xfer_dir && fill > hi_ext && cfg_rdata[15] && !cfg_we)
        |=> rx_dma_req);

    // R7
    tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_dir && fill < lo_ext && !cfg_rdata[7] && !cfg_we)
        |=> tx_lvl_flag);

    // R8
    one_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_dma_req, rx_lvl_flag, tx_dma_req, tx_lvl_flag}));

    // R9
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && fill == '0)
        |=> !(rx_dma_req || rx_lvl_flag || tx_dma_req || tx_lvl_flag));

    // R10
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[15]) |=> !rx_lvl_flag);
endmodule

bind mcf_top mcf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop         (pop),
    .rd_data     (rd_data),
    .fill        (fill),
    .xfer_active (xfer_active),
    .xfer_dir    (xfer_dir),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req),
    .rx_lvl_flag (rx_lvl_flag),
    .tx_lvl_flag (tx_lvl_flag)
);

// File: tb/sim_mcf_top.sv
`timescale 1ns/1ps
module sim_mcf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  fill;
    logic        xfer_active = 1'b1, xfer_dir = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mq[$];
    int m_hi = 31, m_lo = 0;
    bit m_rxen = 0, m_txen = 0;
    logic [15:0] next_w = 16'h5A5A;

    always #5 clk = ~clk;

    mcf_top u0 (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data), .pop(pop),
        .rd_data(rd_data), .fill(fill), .xfer_active(xfer_active),
        .xfer_dir(xfer_dir), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_lvl_flag(rx_lvl_flag), .tx_lvl_flag(tx_lvl_flag)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] exp_ind(int n);
        logic [3:0] r = '0;
        if (!xfer_active && n == 0) return r;
        if (xfer_dir && n > m_hi)  r[3:2] = m_rxen ? 2'b10 : 2'b01;
        if (!xfer_dir && n < m_lo) r[1:0] = m_txen ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic logic [3:0] got_ind();
        return {rx_dma_req, rx_lvl_flag, tx_dma_req, tx_lvl_flag};
    endfunction

    task automatic set_cfg(bit rxen, int hi, bit txen, int lo);
        cfg_we = 1'b1;
        cfg_wdata = {rxen, 2'b00, 5'(hi), txen, 2'b00, 5'(lo)};
        m_rxen = rxen; m_hi = hi; m_txen = txen; m_lo = lo;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic op(bit p, bit q);
        int  sz = mq.size();
        bit  pa = p && sz != 32;
        bit  qa = q && sz != 0;
        push = p; pop = q; wr_data = next_w;
        if (qa) begin
            check("R1 head word", rd_data, mq[0]);
            void'(mq.pop_front());
        end
        if (pa) mq.push_back(next_w);
        next_w = next_w + 16'h0133;
        tick();
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic settle_check(string tag);
        tick();
        check({tag, " fill"}, fill, mq.size());
        check({tag, " indications"}, got_ind(), exp_ind(mq.size()));
    endtask

    task automatic sweep(bit dir, bit rxen, int hi, bit txen, int lo);
        logic [15:0] held;
        xfer_dir = dir;
        set_cfg(rxen, hi, txen, lo);
        op(1, 0); op(0, 1);
        settle_check(dir ? "R6 R8 empty" : "R7 R8 empty");
        for (int i = 0; i < 32; i++) begin
            op(1, 0);
            settle_check(dir ? "R6 R8 fill" : "R7 R8 fill");
        end
        op(1, 0);
        check("R2 push at full", fill, 32);
        for (int i = 0; i < 32; i++) begin
            op(0, 1);
            settle_check(dir ? "R6 R8 drain" : "R7 R8 drain");
        end
        held = rd_data;
        op(0, 1);
        check("R3 fill after empty pop", fill, 0);
        check("R3 head after empty pop", rd_data, held);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R5 reset cfg", cfg_rdata, 16'h1F00);
        check("R5 reset fill", fill, 0);
        check("R9 reset indications", got_ind(), 0);
        rst_n = 1'b1;
        tick();

        sweep(1, 0, 0, 0, 0);
        sweep(1, 1, 13, 0, 0);
        sweep(1, 0, 31, 1, 31);
        sweep(0, 0, 31, 1, 0);
        sweep(0, 0, 31, 0, 9);
        sweep(0, 1, 0, 1, 31);

        // R5 layout readback
        set_cfg(1, 5, 1, 22);
        check("R5 cfg layout", cfg_rdata, 16'h8596);
        set_cfg(0, 31, 0, 0);

        // R9 idle and empty forces everything low
        xfer_dir = 0; xfer_active = 0;
        set_cfg(0, 31, 0, 9);
        settle_check("R9 idle empty");
        check("R9 tx flag off", tx_lvl_flag, 0);
        op(1, 0);
        settle_check("R9 idle one word");
        check("R9 tx flag with data", tx_lvl_flag, 1);
        op(0, 1);
        xfer_active = 1;
        settle_check("R9 active empty");
        check("R7 active empty flag", tx_lvl_flag, 1);

        // R11 one-cycle lag after push
        xfer_dir = 1;
        set_cfg(1, 0, 0, 0);
        settle_check("R11 base");
        op(1, 0);
        check("R11 fill at once", fill, 1);
        check("R11 req lags", rx_dma_req, 0);
        tick();
        check("R11 req next edge", rx_dma_req, 1);

        // R10 enabling DMA drops the flag on the loading edge
        set_cfg(0, 0, 0, 0);
        settle_check("R10 flag up");
        check("R10 flag before", rx_lvl_flag, 1);
        set_cfg(1, 0, 0, 0);
        check("R10 flag cleared", rx_lvl_flag, 0);
        check("R10 req raised", rx_dma_req, 1);
        op(0, 1);

        // R4 concurrent push and pop
        tick();
        op(1, 1);
        check("R4 both at empty", fill, 1);
        for (int i = 0; i < 5; i++) begin
            op(1, 1);
            check("R4 both mid", fill, 1);
        end
        while (mq.size() < 32) op(1, 0);
        op(1, 1);
        check("R4 both at full", fill, 31);
        while (mq.size() > 0) op(0, 1);
        check("R1 drained", fill, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule